// File: doc/BRIEF.md
# Per-Peripheral Clock Gating Unit

This block holds a power-reduction register with one bit for each of up to eight peripherals. A set bit removes that peripheral's clock enable, so the peripheral keeps whatever state it had at that moment. A cleared bit gives the clock back, and the peripheral carries on from that held state. No reset is ever sent to a peripheral by this unit. The glitch-free clock-gate cells that follow the block are represented here only by their enable inputs.

The unit also sits between a simple register bus and the peripherals' register files. It forwards strobes, a local offset and write data only to peripherals that are clocked. An access to a gated peripheral is absorbed: a write is dropped, a read returns zero, and a sticky per-peripheral flag records the attempt. A global deep-sleep input switches off every clock enable without changing the register, because the gating bits only matter in the run and idle states. Each peripheral's request line to shared arbitration is forwarded one cycle late whether the peripheral is gated or not, so no claimed resource is released.

Address map: when address bit ADDR_W-1 is 0 the access targets the control space, where offset 0 is the gating register, offset 1 is the blocked-access flags, and every other offset is unmapped. When that bit is 1, bits [LOCAL_W+IDX_W-1:LOCAL_W] select the peripheral and bits [LOCAL_W-1:0] give the offset inside it.

Top module: `pclk_gate_unit`

## Requirements
- R1: After a synchronous reset the gating register and the blocked-access flags are all zero, every `clk_en` bit is 1, all strobes are 0, `bus_rdata` is 0 and `arb_req` is 0.
- R2: A write to control offset 0 loads the low N_PERIPH bits of `bus_wdata` into the gating register, readable at that offset; `clk_en[i]` becomes the inverse of bit i one edge after the edge that captures the write and not earlier.
- R3: While `deep_sleep` is 1, every `clk_en` bit is 0 from the following edge on, whatever the register holds; the register keeps its value, and once `deep_sleep` returns to 0 the enables again follow its inverse one edge later.
- R4: A write to a peripheral whose gating bit is 0 raises only that peripheral's `periph_wr` bit for exactly one cycle after the capturing edge, with `periph_off` equal to the address offset and `periph_wdata` equal to the written data.
- R5: A write to a peripheral whose gating bit is 1 produces no `periph_wr` pulse for any peripheral.
- R6: A read of a peripheral whose gating bit is 0 raises only its `periph_rd` bit for one cycle after the capturing edge, and `bus_rdata` shows that peripheral's `periph_rdata` slice (bits [i*DATA_W +: DATA_W]) two edges after the capturing edge.
- R7: A read of a peripheral whose gating bit is 1 produces no `periph_rd` pulse and `bus_rdata` is 0 two edges after the capturing edge.
- R8: Every blocked access to peripheral i sets flag bit i at control offset 1; a flag stays set until a write of 1 to that bit position at offset 1, and written 0 bits leave flags unchanged.
- R9: `arb_req` equals `periph_req` delayed by one cycle, unaffected by gating bits and by `deep_sleep`.
- R10: Writes to unmapped control offsets change no register and raise no strobe; reads of them return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Register bus address |
| bus_wr | input | 1 | Register bus write enable |
| bus_rd | input | 1 | Register bus read enable |
| bus_wdata | input | DATA_W | Register bus write data |
| bus_rdata | output | DATA_W | Register bus read data, two edges after the read |
| deep_sleep | input | 1 | Deep sleep: forces all clock enables off |
| clk_en | output | N_PERIPH | Per-peripheral clock enable for the gate cells |
| periph_wr | output | N_PERIPH | Per-peripheral write strobe |
| periph_rd | output | N_PERIPH | Per-peripheral read strobe |
| periph_off | output | LOCAL_W | Register offset inside the selected peripheral |
| periph_wdata | output | DATA_W | Write data toward the peripherals |
| periph_rdata | input | N_PERIPH*DATA_W | Read data from all peripherals, packed |
| periph_req | input | N_PERIPH | Request lines from the peripherals |
| arb_req | output | N_PERIPH | Request lines toward arbitration, one cycle late |

## Verification
Strobes, request forwarding and the sleep override appear one edge after the edge that captures the stimulus, clock enables after a register write appear two edges later, and read data appears two edges after the read is captured. The bench drives on falling edges and samples on falling edges, counting edges explicitly: strobes are read at the first falling edge after the capture, read data at the second, and clock enables are checked at the first falling edge to still hold the old value and at the second to hold the new one, so that an early change is caught as well as a late one.

// File: rtl/pcg_pkg.sv
package pcg_pkg;
  typedef enum logic [1:0] {
    SRC_ZERO   = 2'd0,
    SRC_GATE   = 2'd1,
    SRC_STAT   = 2'd2,
    SRC_PERIPH = 2'd3
  } rd_src_e;

  localparam int OFF_GATE = 0;
  localparam int OFF_STAT = 1;
endpackage

// File: rtl/pcg_decode.sv
module pcg_decode
  import pcg_pkg::*;
#(
  parameter int N_PERIPH = 8,
  parameter int LOCAL_W  = 2,
  parameter int IDX_W    = 3,
  parameter int ADDR_W   = 6
) (
  input  logic [ADDR_W-1:0]  addr,
  input  logic               wr,
  input  logic               rd,
  input  logic [N_PERIPH-1:0] gate,
  output logic               wr_gate,
  output logic               wr_stat,
  output logic [N_PERIPH-1:0] acc_wr,
  output logic [N_PERIPH-1:0] acc_rd,
  output logic [N_PERIPH-1:0] blocked,
  output rd_src_e            rd_src,
  output logic [IDX_W-1:0]   rd_idx,
  output logic [LOCAL_W-1:0] off
);
  localparam int CTRL_W = ADDR_W - 1;

  logic               is_periph;
  logic [CTRL_W-1:0]  ctrl_off;
  logic [IDX_W-1:0]   idx;
  logic [N_PERIPH-1:0] hit;

  assign is_periph = addr[ADDR_W-1];
  assign ctrl_off  = addr[CTRL_W-1:0];
  assign idx       = addr[LOCAL_W +: IDX_W];
  assign off       = addr[LOCAL_W-1:0];
  assign rd_idx    = idx;

  generate
    for (genvar gi = 0; gi < N_PERIPH; gi++) begin : g_hit
      assign hit[gi]     = is_periph && (idx == IDX_W'(gi));
      assign acc_wr[gi]  = hit[gi] & wr & ~gate[gi];
      assign acc_rd[gi]  = hit[gi] & rd & ~gate[gi];
      assign blocked[gi] = hit[gi] & (wr | rd) & gate[gi];
    end
  endgenerate

  assign wr_gate = wr & ~is_periph & (ctrl_off == CTRL_W'(OFF_GATE));
  assign wr_stat = wr & ~is_periph & (ctrl_off == CTRL_W'(OFF_STAT));

  always_comb begin
    rd_src = SRC_ZERO;
    if (rd) begin
      if (!is_periph) begin
        if (ctrl_off == CTRL_W'(OFF_GATE))      rd_src = SRC_GATE;
        else if (ctrl_off == CTRL_W'(OFF_STAT)) rd_src = SRC_STAT;
      end else if (|(hit & ~gate)) begin
        rd_src = SRC_PERIPH;
      end
    end
  end
endmodule

// File: rtl/pcg_regs.sv
module pcg_regs #(
  parameter int N_PERIPH = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_gate,
  input  logic               wr_stat,
  input  logic [N_PERIPH-1:0] wdata,
  input  logic [N_PERIPH-1:0] blocked,
  output logic [N_PERIPH-1:0] gate_q,
  output logic [N_PERIPH-1:0] stat_q
);
  logic [N_PERIPH-1:0] clr_mask;

  assign clr_mask = wr_stat ? wdata : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      gate_q <= '0;
      stat_q <= '0;
    end else begin
      if (wr_gate) gate_q <= wdata;
      // a new blocked access wins over a clear in the same cycle
      stat_q <= (stat_q & ~clr_mask) | blocked;
    end
  end
endmodule

// File: rtl/pcg_clken.sv
module pcg_clken #(
  parameter int N_PERIPH = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_PERIPH-1:0] gate,
  input  logic               deep_sleep,
  output logic [N_PERIPH-1:0] clk_en
);
  generate
    for (genvar gi = 0; gi < N_PERIPH; gi++) begin : g_en
      always_ff @(posedge clk) begin
        if (rst) clk_en[gi] <= 1'b1;
        else     clk_en[gi] <= ~gate[gi] & ~deep_sleep;
      end
    end
  endgenerate
endmodule

// File: rtl/pcg_port.sv
module pcg_port
  import pcg_pkg::*;
#(
  parameter int N_PERIPH = 8,
  parameter int DATA_W   = 8,
  parameter int LOCAL_W  = 2,
  parameter int IDX_W    = 3
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [N_PERIPH-1:0]        acc_wr,
  input  logic [N_PERIPH-1:0]        acc_rd,
  input  logic                       rd,
  input  rd_src_e                    rd_src,
  input  logic [IDX_W-1:0]           rd_idx,
  input  logic [LOCAL_W-1:0]         off,
  input  logic [DATA_W-1:0]          wdata,
  input  logic [N_PERIPH-1:0]        gate,
  input  logic [N_PERIPH-1:0]        stat,
  input  logic [N_PERIPH*DATA_W-1:0] prdata,
  output logic [N_PERIPH-1:0]        pwr,
  output logic [N_PERIPH-1:0]        prd,
  output logic [LOCAL_W-1:0]         poff,
  output logic [DATA_W-1:0]          pwdata,
  output logic [DATA_W-1:0]          rdata
);
  logic                rd_pend_q;
  rd_src_e             src_q;
  logic [IDX_W-1:0]    idx_q;
  logic [N_PERIPH-1:0] ctrl_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pwr       <= '0;
      prd       <= '0;
      poff      <= '0;
      pwdata    <= '0;
      rd_pend_q <= 1'b0;
      src_q     <= SRC_ZERO;
      idx_q     <= '0;
      ctrl_q    <= '0;
      rdata     <= '0;
    end else begin
      pwr <= acc_wr;
      prd <= acc_rd;
      if (|acc_wr || |acc_rd) poff <= off;
      if (|acc_wr) pwdata <= wdata;
      rd_pend_q <= rd;
      src_q     <= rd_src;
      idx_q     <= rd_idx;
      ctrl_q    <= (rd_src == SRC_STAT) ? stat : gate;
      if (rd_pend_q) begin
        case (src_q)
          SRC_PERIPH:        rdata <= prdata[int'(idx_q)*DATA_W +: DATA_W];
          SRC_GATE, SRC_STAT: rdata <= DATA_W'(ctrl_q);
          default:           rdata <= '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/pclk_gate_unit.sv
module pclk_gate_unit
  import pcg_pkg::*;
#(
  parameter int N_PERIPH = 8,
  parameter int DATA_W   = 8,
  parameter int LOCAL_W  = 2,
  parameter int IDX_W    = (N_PERIPH > 1) ? $clog2(N_PERIPH) : 1,
  parameter int ADDR_W   = 1 + IDX_W + LOCAL_W
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [ADDR_W-1:0]          bus_addr,
  input  logic                       bus_wr,
  input  logic                       bus_rd,
  input  logic [DATA_W-1:0]          bus_wdata,
  output logic [DATA_W-1:0]          bus_rdata,
  input  logic                       deep_sleep,
  output logic [N_PERIPH-1:0]        clk_en,
  output logic [N_PERIPH-1:0]        periph_wr,
  output logic [N_PERIPH-1:0]        periph_rd,
  output logic [LOCAL_W-1:0]         periph_off,
  output logic [DATA_W-1:0]          periph_wdata,
  input  logic [N_PERIPH*DATA_W-1:0] periph_rdata,
  input  logic [N_PERIPH-1:0]        periph_req,
  output logic [N_PERIPH-1:0]        arb_req
);
  logic                wr_gate;
  logic                wr_stat;
  logic [N_PERIPH-1:0] acc_wr;
  logic [N_PERIPH-1:0] acc_rd;
  logic [N_PERIPH-1:0] blocked;
  rd_src_e             rd_src;
  logic [IDX_W-1:0]    rd_idx;
  logic [LOCAL_W-1:0]  off;
  logic [N_PERIPH-1:0] gate_q;
  logic [N_PERIPH-1:0] stat_q;

  pcg_decode #(
    .N_PERIPH(N_PERIPH), .LOCAL_W(LOCAL_W), .IDX_W(IDX_W), .ADDR_W(ADDR_W)
  ) u_decode (
    .addr(bus_addr), .wr(bus_wr), .rd(bus_rd), .gate(gate_q),
    .wr_gate(wr_gate), .wr_stat(wr_stat), .acc_wr(acc_wr), .acc_rd(acc_rd),
    .blocked(blocked), .rd_src(rd_src), .rd_idx(rd_idx), .off(off)
  );

  pcg_regs #(.N_PERIPH(N_PERIPH)) u_regs (
    .clk(clk), .rst(rst), .wr_gate(wr_gate), .wr_stat(wr_stat),
    .wdata(bus_wdata[N_PERIPH-1:0]), .blocked(blocked),
    .gate_q(gate_q), .stat_q(stat_q)
  );

  pcg_clken #(.N_PERIPH(N_PERIPH)) u_clken (
    .clk(clk), .rst(rst), .gate(gate_q), .deep_sleep(deep_sleep), .clk_en(clk_en)
  );

  pcg_port #(
    .N_PERIPH(N_PERIPH), .DATA_W(DATA_W), .LOCAL_W(LOCAL_W), .IDX_W(IDX_W)
  ) u_port (
    .clk(clk), .rst(rst), .acc_wr(acc_wr), .acc_rd(acc_rd), .rd(bus_rd),
    .rd_src(rd_src), .rd_idx(rd_idx), .off(off), .wdata(bus_wdata),
    .gate(gate_q), .stat(stat_q), .prdata(periph_rdata),
    .pwr(periph_wr), .prd(periph_rd), .poff(periph_off),
    .pwdata(periph_wdata), .rdata(bus_rdata)
  );

  // request lines stay asserted through gating so claimed resources are kept
  always_ff @(posedge clk) begin
    if (rst) arb_req <= '0;
    else     arb_req <= periph_req;
  end
endmodule

// File: rtl/pclk_gate_unit_chk.sv
module pclk_gate_unit_chk #(
  parameter int N_PERIPH = 8,
  parameter int DATA_W   = 8,
  parameter int LOCAL_W  = 2,
  parameter int IDX_W    = 3,
  parameter int ADDR_W   = 6
) (
  input logic                clk,
  input logic                rst,
  input logic [ADDR_W-1:0]   bus_addr,
  input logic                bus_wr,
  input logic                bus_rd,
  input logic [DATA_W-1:0]   bus_rdata,
  input logic                deep_sleep,
  input logic [N_PERIPH-1:0] clk_en,
  input logic [N_PERIPH-1:0] periph_wr,
  input logic [N_PERIPH-1:0] periph_rd,
  input logic [N_PERIPH-1:0] periph_req,
  input logic [N_PERIPH-1:0] arb_req,
  input logic [N_PERIPH-1:0] gate,
  input logic [N_PERIPH-1:0] stat
);
  localparam int CTRL_W = ADDR_W - 1;

  logic             to_periph;
  logic [IDX_W-1:0] tgt;
  logic             tgt_gated;
  logic             stat_write;

  assign to_periph  = bus_addr[ADDR_W-1];
  assign tgt        = bus_addr[LOCAL_W +: IDX_W];
  assign tgt_gated  = to_periph && (int'(tgt) < N_PERIPH) && gate[tgt];
  assign stat_write = bus_wr && !to_periph && (bus_addr[CTRL_W-1:0] == CTRL_W'(1));

  AST_RESET_CLK_ON: assert property (@(posedge clk)
    rst |=> (clk_en == '1 && gate == '0 && stat == '0 && arb_req == '0)); // R1

  AST_CLKEN_TRACKS_GATE: assert property (@(posedge clk) disable iff (rst)
    !deep_sleep |=> (clk_en == ~$past(gate))); // R2

  AST_SLEEP_STOPS_ALL: assert property (@(posedge clk) disable iff (rst)
    deep_sleep |=> (clk_en == '0)); // R3

  AST_ONE_WRITE_STROBE: assert property (@(posedge clk) disable iff (rst)
    $onehot0(periph_wr) && $onehot0(periph_rd)); // R4

  AST_GATED_WRITE_DROPPED: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && tgt_gated) |=> (periph_wr == '0)); // R5

  AST_GATED_READ_BLOCKED: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && tgt_gated) |=> (periph_rd == '0)); // R7

  AST_GATED_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && tgt_gated) |=> ##1 (bus_rdata == '0)); // R7

  AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (rst)
    !stat_write |=> ((stat & $past(stat)) == $past(stat))); // R8

  AST_REQ_FORWARDED: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (arb_req == $past(periph_req))); // R9
endmodule

bind pclk_gate_unit pclk_gate_unit_chk #(
  .N_PERIPH(N_PERIPH), .DATA_W(DATA_W), .LOCAL_W(LOCAL_W),
  .IDX_W(IDX_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_rdata(bus_rdata), .deep_sleep(deep_sleep), .clk_en(clk_en),
  .periph_wr(periph_wr), .periph_rd(periph_rd), .periph_req(periph_req),
  .arb_req(arb_req), .gate(gate_q), .stat(stat_q)
);

// File: tb/test_pclk_gate_unit.sv
`timescale 1ns/1ps
module test_pclk_gate_unit;
  localparam int N  = 8;
  localparam int DW = 8;
  localparam int LW = 2;
  localparam int AW = 6;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] bus_addr = '0;
  logic          bus_wr = 1'b0;
  logic          bus_rd = 1'b0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic          deep_sleep = 1'b0;
  logic [N-1:0]  clk_en, periph_wr, periph_rd, arb_req;
  logic [N-1:0]  periph_req = '0;
  logic [LW-1:0] periph_off;
  logic [DW-1:0] periph_wdata;
  logic [N*DW-1:0] periph_rdata;

  int total = 0;
  int bad   = 0;

  always #5 clk = ~clk;

  pclk_gate_unit i_pclk_gate_unit (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .deep_sleep(deep_sleep),
    .clk_en(clk_en), .periph_wr(periph_wr), .periph_rd(periph_rd),
    .periph_off(periph_off), .periph_wdata(periph_wdata),
    .periph_rdata(periph_rdata), .periph_req(periph_req), .arb_req(arb_req)
  );

  function automatic logic [DW-1:0] model(input int i, input int off);
    return DW'((i * 37 + off * 11) ^ 8'h5A);
  endfunction

  always_comb begin
    for (int i = 0; i < N; i++) periph_rdata[i*DW +: DW] = model(i, int'(periph_off));
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [AW-1:0] a, output logic [N-1:0] seen,
                          output logic [DW-1:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    @(negedge clk); bus_rd = 1'b0; seen = periph_rd;
    @(negedge clk); d = bus_rdata;
  endtask

  function automatic logic [AW-1:0] paddr(input int i, input int off);
    return {1'b1, 3'(i), 2'(off)};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog act=%h exp=%h", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [N-1:0]  seen;
    logic [DW-1:0] d;
    logic [N-1:0]  prev_g;
    logic [N-1:0]  stat_exp;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk(clk_en == '1, "R1 clk_en", 32'(clk_en), 32'hFF);
    chk(periph_wr == '0 && periph_rd == '0, "R1 strobes", 32'({periph_wr, periph_rd}), 0);
    chk(bus_rdata == '0 && arb_req == '0, "R1 rdata/req", 32'({bus_rdata, arb_req}), 0);
    bus_read(6'd0, seen, d);
    chk(d == '0, "R1 gate reg", 32'(d), 0);
    bus_read(6'd1, seen, d);
    chk(d == '0, "R1 flags", 32'(d), 0);

    prev_g   = '0;
    stat_exp = '0;
    for (int g = 0; g < 256; g++) begin
      logic [N-1:0] gv;
      gv = N'(g);
      bus_write(6'd0, gv);
      chk(periph_wr == '0, "R2 no strobe on ctrl write", 32'(periph_wr), 0);
      chk(clk_en == ~prev_g, "R2 enable not early", 32'(clk_en), 32'(~prev_g));
      @(negedge clk);
      chk(clk_en == ~gv, "R2 enable follows", 32'(clk_en), 32'(~gv));
      bus_read(6'd0, seen, d);
      chk(d == DW'(gv), "R2 readback", 32'(d), 32'(gv));
      prev_g = gv;

      // R9: request forwarding ignores gating
      @(negedge clk); periph_req = gv ^ 8'h3C;
      @(negedge clk);
      chk(arb_req == (gv ^ 8'h3C), "R9 req forwarded", 32'(arb_req), 32'(gv ^ 8'h3C));

      for (int i = 0; i < N; i++) begin
        logic [DW-1:0] wd;
        int off;
        off = (i + g) % 4;
        wd  = DW'(g ^ (i * 29));
        bus_write(paddr(i, off), wd);
        if (gv[i]) begin
          chk(periph_wr == '0, "R5 gated write dropped", 32'(periph_wr), 0);
        end else begin
          chk(periph_wr == N'(1 << i), "R4 write strobe", 32'(periph_wr), 32'(1 << i));
          chk(periph_wdata == wd && periph_off == LW'(off), "R4 write data/offset",
              32'({periph_off, periph_wdata}), 32'({LW'(off), wd}));
        end
        @(negedge clk);
        chk(periph_wr == '0, "R4 single pulse", 32'(periph_wr), 0);
        bus_read(paddr(i, off), seen, d);
        if (gv[i]) begin
          chk(seen == '0, "R7 no read strobe", 32'(seen), 0);
          chk(d == '0, "R7 read zero", 32'(d), 0);
        end else begin
          chk(seen == N'(1 << i), "R6 read strobe", 32'(seen), 32'(1 << i));
          chk(d == model(i, off), "R6 read data", 32'(d), 32'(model(i, off)));
        end
      end
      stat_exp |= gv;
      bus_read(6'd1, seen, d);
      chk(d == DW'(stat_exp), "R8 flags", 32'(d), 32'(stat_exp));
      if (g % 2 == 0) begin
        bus_write(6'd1, 8'hFF);
        stat_exp = '0;
      end else begin
        bus_write(6'd1, 8'h0F);
        stat_exp &= ~N'(8'h0F);
      end
      bus_read(6'd1, seen, d);
      chk(d == DW'(stat_exp), "R8 flag clear", 32'(d), 32'(stat_exp));

      if (g % 17 == 0) begin
        // R3: sleep override
        @(negedge clk); deep_sleep = 1'b1;
        @(negedge clk);
        chk(clk_en == '0, "R3 sleep stops", 32'(clk_en), 0);
        bus_read(6'd0, seen, d);
        chk(d == DW'(gv), "R3 register kept", 32'(d), 32'(gv));
        chk(clk_en == '0, "R3 still stopped", 32'(clk_en), 0);
        @(negedge clk); deep_sleep = 1'b0;
        @(negedge clk);
        chk(clk_en == ~gv, "R3 wake restores", 32'(clk_en), 32'(~gv));
      end

      if (g % 51 == 5) begin
        // R10: unmapped control offsets
        bus_write(6'd2, ~gv);
        chk(periph_wr == '0, "R10 no strobe", 32'(periph_wr), 0);
        bus_read(6'd0, seen, d);
        chk(d == DW'(gv), "R10 gate unchanged", 32'(d), 32'(gv));
        bus_read(6'd3, seen, d);
        chk(d == '0 && seen == '0, "R10 read zero", 32'(d), 0);
        bus_read(6'd1, seen, d);
        chk(d == DW'(stat_exp), "R10 flags unchanged", 32'(d), 32'(stat_exp));
      end
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule